// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, two-digit year (2000 to 2099) and a binary day-of-week count. A single-cycle pulse on the tick input, normally once per second, advances the seconds. Each field that wraps passes a carry to the next field. Day of month and day of week both advance when the hours wrap at midnight. The month length, including leap Februaries, sets where the day of month wraps.

Software reaches the fields through a byte-wide register port. This port has an address, write data, a write strobe and a combinational read-data output. The seven time fields sit at consecutive byte addresses starting at zero. Software normally loads or reads them as one burst. A control byte holds a write-enable bit. Time-field writes take effect only while that bit is set. The hour byte also carries a 24-hour-mode flag in its top bit, which software sets whenever it loads the time. Counting is always 24-hour.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the time fields read as follows: seconds 0x00, minutes 0x00, hours 0x00 (mode flag clear), day of month 0x01, month 0x01, year 0x00, day of week 0x00. The control byte reads 0x00.
- R2: The address map is: 0 seconds, 1 minutes, 2 hours, 3 day of month, 4 month, 5 year, 6 day of week. Address 8 is the control byte, whose bit 6 is the write enable. All other control bits, and every unmapped address, read as zero.
- R3: A loaded value keeps only the significant bits of its field: bits 6:0 for seconds and minutes, 5:0 for hours and day of month, 4:0 for month, 7:0 for year, and 2:0 for day of week. Bit 7 of an hour write is stored as the mode flag and reads back in bit 7; hour bit 6 reads zero.
- R4: A write to addresses 0 to 6 while control bit 6 is clear leaves every time field unchanged. The control byte can always be written.
- R5: Each tick advances seconds. Seconds wrap 0x59→0x00 and carry into minutes. Minutes wrap 0x59→0x00 and carry into hours.
- R6: Hours wrap 0x23→0x00 and advance both day of month and day of week. Day of week counts 0 to 6 and wraps 6→0.
- R7: Day of month wraps to 0x01 after its last day and carries into month. The last day is 0x30 for months 0x04, 0x06, 0x09 and 0x11. It is 0x29 for month 0x02 when the year is divisible by 4, and 0x28 for month 0x02 otherwise. It is 0x31 for every other month.
- R8: Month wraps 0x12→0x01 and carries into year. Year wraps 0x99→0x00.
- R9: A tick arriving in the same cycle as an accepted time-field write is dropped. The write lands, and no field advances in that cycle.
- R10: Without a tick or a write, every field holds its value.
- R11: A field holding a value at or above its wrap point returns to its low value (0x00, or 0x01 for day of month and month) on its next advance, and passes a carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse that advances the time by one second |
| addr_i | input | ADDR_W (4) | Register byte address |
| wr_i | input | 1 | Write strobe for the addressed register |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register (combinational) |

## Verification
The bench builds the block with its default parameters: a 4-bit address, the control byte at address 8 and the enable in bit 6. A default build reaches every calendar corner, because the bench loads the fields directly to a second before each boundary. It does not count up a full day of ticks. This direct loading reaches the following cases:
- leap and common Februaries, including year 00;
- the 30- and 31-day months;
- the year wrap on the last second of 2099;
- a day-of-week wrap;
- out-of-range loaded values;
- a tick that coincides with a write.

// File: rtl/cal_pkg.sv
// Shared constants and helpers for the BCD calendar.
// Assumes byte-wide BCD fields and the fixed field order used by the address map.
package cal_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned NUM_FIELDS = 7;
    localparam int unsigned IDX_SEC    = 0;
    localparam int unsigned IDX_MIN    = 1;
    localparam int unsigned IDX_HOUR   = 2;
    localparam int unsigned IDX_DATE   = 3;
    localparam int unsigned IDX_MONTH  = 4;
    localparam int unsigned IDX_YEAR   = 5;
    localparam int unsigned IDX_DOW    = 6;
    localparam int unsigned MODE_BIT   = 7;

    typedef logic [NUM_FIELDS-1:0][BYTE_W-1:0] time_regs_t;

    // Significant bits kept when a field is loaded.
    function automatic logic [BYTE_W-1:0] field_mask(int unsigned idx);
        case (idx)
            IDX_SEC, IDX_MIN:   return 8'h7F;
            IDX_HOUR, IDX_DATE: return 8'h3F;
            IDX_MONTH:          return 8'h1F;
            IDX_YEAR:           return 8'hFF;
            default:            return 8'h07;
        endcase
    endfunction

    // Value a field resets to and returns to on wrap.
    function automatic logic [BYTE_W-1:0] field_low(int unsigned idx);
        return (idx == IDX_DATE || idx == IDX_MONTH) ? 8'h01 : 8'h00;
    endfunction

    // Fixed wrap point; the day of month uses a computed one instead.
    function automatic logic [BYTE_W-1:0] field_top(int unsigned idx);
        case (idx)
            IDX_SEC, IDX_MIN: return 8'h59;
            IDX_HOUR:         return 8'h23;
            IDX_DATE:         return 8'h31;
            IDX_MONTH:        return 8'h12;
            IDX_YEAR:         return 8'h99;
            default:          return 8'h06;
        endcase
    endfunction

    // Two-digit BCD increment (no wrap; the caller handles the limit).
    function automatic logic [BYTE_W-1:0] bcd_next(logic [BYTE_W-1:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'h0};
        return v + 8'd1;
    endfunction

    // Two-digit BCD year divisible by 4: 10 is 2 mod 4, so test 2*tens+units.
    function automatic logic leap_bcd(logic [BYTE_W-1:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return s[1:0] == 2'b00;
    endfunction
endpackage

// File: rtl/cal_field.sv
// One BCD time field: loads masked data, or steps with wrap to its low value.
// Assumes limit_i is a valid BCD wrap point; values at or above it wrap.
module cal_field
    import cal_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MASK = 8'hFF,
    parameter logic [BYTE_W-1:0] LOW  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              step_i,
    input  logic [BYTE_W-1:0] limit_i,
    output logic [BYTE_W-1:0] value_o
);
    logic [BYTE_W-1:0] value_q;

    // Field register: load has priority over a counting step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            value_q <= LOW;
        else if (load_i)
            value_q <= load_val_i & MASK;
        else if (step_i)
            value_q <= (value_q >= limit_i) ? LOW : (bcd_next(value_q) & MASK);
    end

    assign value_o = value_q;
endmodule

// File: rtl/cal_month_len.sv
// Last day of the month in BCD, from the BCD month and two-digit year.
// Assumes every year divisible by 4 is a leap year (valid for 2000-2099).
module cal_month_len
    import cal_pkg::*;
(
    input  logic [BYTE_W-1:0] month_i,
    input  logic [BYTE_W-1:0] year_i,
    output logic [BYTE_W-1:0] last_day_o
);
    // Month length lookup.
    always_comb begin
        case (month_i)
            8'h02:                      last_day_o = leap_bcd(year_i) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
            default:                    last_day_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/cal_ctrl.sv
// Write decode and control state: write-enable bit and hour mode flag.
// Assumes time fields occupy addresses 0..NUM_FIELDS-1.
module cal_ctrl
    import cal_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic                  wren_bit_i,
    input  logic                  mode_bit_i,
    output logic                  wren_o,
    output logic                  mode_o,
    output logic [NUM_FIELDS-1:0] load_o
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic wren_q;
    logic mode_q;

    // Per-field load strobes, gated by the write enable.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_dec
        assign load_o[i] = wr_i && wren_q && (addr_i == ADDR_W'(i));
    end

    // Write-enable bit, always writable through the control byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wren_q <= 1'b0;
        else if (wr_i && addr_i == CTRL_A)
            wren_q <= wren_bit_i;
    end

    // Hour mode flag, stored along with an accepted hour load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else if (load_o[IDX_HOUR])
            mode_q <= mode_bit_i;
    end

    assign wren_o = wren_q;
    assign mode_o = mode_q;
endmodule

// File: rtl/bcd_calendar.sv
// BCD calendar: seven time fields advanced by a tick, with a byte register port.
// Assumes tick_i is a one-cycle pulse and ADDR_W is at least 3 and wide enough for CTRL_ADDR.
module bcd_calendar
    import cal_pkg::*;
#(
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CTRL_ADDR = 8,
    parameter int unsigned WREN_BIT  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] NFLD_A  = ADDR_W'(NUM_FIELDS);
    localparam logic [ADDR_W-1:0] HOUR_A  = ADDR_W'(IDX_HOUR);
    localparam int unsigned       CARRY_N = IDX_MONTH + 1;

    time_regs_t               fld_q;
    time_regs_t               limit;
    logic [NUM_FIELDS-1:0]    load;
    logic [NUM_FIELDS-1:0]    step;
    logic [CARRY_N-1:0]       wrap;
    logic [BYTE_W-1:0]        last_day;
    logic                     wren_q;
    logic                     mode_q;

    cal_ctrl #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR)
    ) i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_i),
        .addr_i     (addr_i),
        .wren_bit_i (wdata_i[WREN_BIT]),
        .mode_bit_i (wdata_i[MODE_BIT]),
        .wren_o     (wren_q),
        .mode_o     (mode_q),
        .load_o     (load)
    );

    cal_month_len i_mlen (
        .month_i    (fld_q[IDX_MONTH]),
        .year_i     (fld_q[IDX_YEAR]),
        .last_day_o (last_day)
    );

    // Carry chain: a dropped tick when any field is being loaded.
    assign step[IDX_SEC]   = tick_i && !(|load);
    assign step[IDX_MIN]   = step[IDX_SEC]   && wrap[IDX_SEC];
    assign step[IDX_HOUR]  = step[IDX_MIN]   && wrap[IDX_MIN];
    assign step[IDX_DATE]  = step[IDX_HOUR]  && wrap[IDX_HOUR];
    assign step[IDX_DOW]   = step[IDX_HOUR]  && wrap[IDX_HOUR];
    assign step[IDX_MONTH] = step[IDX_DATE]  && wrap[IDX_DATE];
    assign step[IDX_YEAR]  = step[IDX_MONTH] && wrap[IDX_MONTH];

    // Field instances; the day of month takes its wrap point from the month length.
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        if (i == IDX_DATE) begin : g_lim_dyn
            assign limit[i] = last_day;
        end else begin : g_lim_fix
            assign limit[i] = field_top(i);
        end
        if (i < CARRY_N) begin : g_wrap
            assign wrap[i] = fld_q[i] >= limit[i];
        end
        cal_field #(
            .MASK (field_mask(i)),
            .LOW  (field_low(i))
        ) i_field (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (load[i]),
            .load_val_i (wdata_i),
            .step_i     (step[i]),
            .limit_i    (limit[i]),
            .value_o    (fld_q[i])
        );
    end

    // Read mux: time fields, hour mode flag, control byte, zero elsewhere.
    always_comb begin
        rdata_o = '0;
        if (addr_i == CTRL_A) begin
            rdata_o[WREN_BIT] = wren_q;
        end else if (addr_i < NFLD_A) begin
            rdata_o = fld_q[addr_i[2:0]];
            if (addr_i == HOUR_A) rdata_o[MODE_BIT] = mode_q;
        end
    end
endmodule

// File: rtl/cal_checker.sv
// Temporal checks on the calendar, bound to every bcd_calendar instance.
// Assumes the default address width and the package field order.
module cal_checker
    import cal_pkg::*;
#(
    parameter int unsigned ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [7:0]        wdata_i,
    input logic              wren_q,
    input time_regs_t        fld_q
);
    logic time_wr;
    logic at_midnight;
    assign time_wr     = wr_i && (addr_i < ADDR_W'(NUM_FIELDS));
    assign at_midnight = fld_q[IDX_SEC] == 8'h59 && fld_q[IDX_MIN] == 8'h59 &&
                         fld_q[IDX_HOUR] == 8'h23;

    p_protect_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        time_wr && !wren_q && !tick_i |=> $stable(fld_q));

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !wr_i |=> $stable(fld_q));

    p_tick_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i && wren_q && addr_i == '0 |=>
            $stable(fld_q[NUM_FIELDS-1:1]) && fld_q[IDX_SEC] == ($past(wdata_i) & 8'h7F));

    p_sec_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !wr_i && fld_q[IDX_SEC] == 8'h59 |=>
            fld_q[IDX_SEC] == 8'h00 && fld_q[IDX_MIN] != $past(fld_q[IDX_MIN]));

    p_dow_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !wr_i && at_midnight && fld_q[IDX_DOW] == 8'h06 |=>
            fld_q[IDX_DOW] == 8'h00);

    p_year_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !wr_i && at_midnight && fld_q[IDX_DATE] == 8'h31 &&
        fld_q[IDX_MONTH] == 8'h12 && fld_q[IDX_YEAR] == 8'h99 |=>
            fld_q[IDX_YEAR] == 8'h00 && fld_q[IDX_MONTH] == 8'h01 &&
            fld_q[IDX_DATE] == 8'h01);
endmodule

bind bcd_calendar cal_checker i_cal_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick_i),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .wren_q  (wren_q),
    .fld_q   (fld_q)
);

// File: tb/test_bcd_calendar.sv
// Directed bench for bcd_calendar: one task per scenario, each checking itself.
module test_bcd_calendar;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic [3:0] addr_i = '0;
    logic       wr_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    bcd_calendar i_bcd_calendar (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .addr_i  (addr_i),
        .wr_i    (wr_i),
        .wdata_i (wdata_i),
        .rdata_o (rdata_o)
    );

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic chk(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr_i = a;
        #1;
        n_chk++;
        if (rdata_o !== exp) begin
            n_fail++;
            $display("FAIL %s addr %0h: got %02h expected %02h", req, a, rdata_o, exp);
        end
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, d, mo, y, w);
        wr(4'h0, s); wr(4'h1, mi); wr(4'h2, h); wr(4'h3, d);
        wr(4'h4, mo); wr(4'h5, y); wr(4'h6, w);
    endtask

    task automatic t_reset();
        chk("R1", 4'h0, 8'h00); chk("R1", 4'h1, 8'h00); chk("R1", 4'h2, 8'h00);
        chk("R1", 4'h3, 8'h01); chk("R1", 4'h4, 8'h01); chk("R1", 4'h5, 8'h00);
        chk("R1", 4'h6, 8'h00); chk("R1", 4'h8, 8'h00);
        chk("R2", 4'h7, 8'h00); chk("R2", 4'hF, 8'h00);
    endtask

    task automatic t_protect();
        wr(4'h0, 8'h12);
        wr(4'h5, 8'h33);
        chk("R4", 4'h0, 8'h00);
        chk("R4", 4'h5, 8'h00);
        wr(4'h8, 8'hFF);
        chk("R2", 4'h8, 8'h40);
        wr(4'h8, 8'h00);
        chk("R4", 4'h8, 8'h00);
        wr(4'h8, 8'h40);
    endtask

    task automatic t_mask();
        wr(4'h0, 8'hFF); chk("R3", 4'h0, 8'h7F);
        wr(4'h2, 8'hFF); chk("R3", 4'h2, 8'hBF);
        wr(4'h3, 8'hFF); chk("R3", 4'h3, 8'h3F);
        wr(4'h4, 8'hFF); chk("R3", 4'h4, 8'h1F);
        wr(4'h5, 8'hA5); chk("R3", 4'h5, 8'hA5);
        wr(4'h6, 8'hFF); chk("R3", 4'h6, 8'h07);
    endtask

    task automatic t_seconds();
        set_time(8'h58, 8'h59, 8'h85, 8'h10, 8'h05, 8'h20, 8'h02);
        tick(); chk("R5", 4'h0, 8'h59); chk("R5", 4'h1, 8'h59);
        tick(); chk("R5", 4'h0, 8'h00); chk("R5", 4'h1, 8'h00);
        chk("R5", 4'h2, 8'h86);
        repeat (5) @(negedge clk);
        chk("R10", 4'h0, 8'h00); chk("R10", 4'h2, 8'h86);
    endtask

    task automatic t_midnight_feb();
        set_time(8'h58, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h23, 8'h06);
        tick(); tick();
        chk("R6", 4'h2, 8'h80); chk("R6", 4'h6, 8'h00);
        chk("R7", 4'h3, 8'h01); chk("R7", 4'h4, 8'h03);
        chk("R8", 4'h5, 8'h23);
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h24, 8'h03);
        tick();
        chk("R7", 4'h3, 8'h29); chk("R7", 4'h4, 8'h02); chk("R6", 4'h6, 8'h04);
        wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'hA3);
        tick();
        chk("R7", 4'h3, 8'h01); chk("R7", 4'h4, 8'h03);
        set_time(8'h59, 8'h59, 8'hA3, 8'h28, 8'h02, 8'h00, 8'h01);
        tick();
        chk("R7", 4'h3, 8'h29);
    endtask

    task automatic t_month_len();
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h04, 8'h50, 8'h00);
        tick(); chk("R7", 4'h3, 8'h01); chk("R7", 4'h4, 8'h05);
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h01, 8'h50, 8'h00);
        tick(); chk("R7", 4'h3, 8'h31); chk("R7", 4'h4, 8'h01);
        wr(4'h0, 8'h59); wr(4'h1, 8'h59); wr(4'h2, 8'hA3);
        tick(); chk("R7", 4'h3, 8'h01); chk("R7", 4'h4, 8'h02);
        set_time(8'h59, 8'h59, 8'hA3, 8'h30, 8'h11, 8'h50, 8'h00);
        tick(); chk("R7", 4'h4, 8'h12);
    endtask

    task automatic t_year_end();
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h99, 8'h05);
        tick();
        chk("R8", 4'h5, 8'h00); chk("R8", 4'h4, 8'h01); chk("R8", 4'h3, 8'h01);
        chk("R8", 4'h6, 8'h06);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h12, 8'h19, 8'h05);
        tick();
        chk("R8", 4'h5, 8'h20);
    endtask

    task automatic t_collision();
        set_time(8'h10, 8'h20, 8'h81, 8'h05, 8'h05, 8'h05, 8'h01);
        @(negedge clk);
        addr_i = 4'h1; wdata_i = 8'h05; wr_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0; tick_i = 1'b0;
        chk("R9", 4'h0, 8'h10); chk("R9", 4'h1, 8'h05);
        wr(4'h8, 8'h00);
        @(negedge clk);
        addr_i = 4'h1; wdata_i = 8'h07; wr_i = 1'b1; tick_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0; tick_i = 1'b0;
        chk("R4", 4'h1, 8'h05); chk("R4", 4'h0, 8'h11);
        wr(4'h8, 8'h40);
    endtask

    task automatic t_overlimit();
        set_time(8'h60, 8'h00, 8'h80, 8'h05, 8'h05, 8'h05, 8'h01);
        tick(); chk("R11", 4'h0, 8'h00); chk("R11", 4'h1, 8'h01);
        set_time(8'h59, 8'h59, 8'hA3, 8'h31, 8'h06, 8'h05, 8'h01);
        tick(); chk("R11", 4'h3, 8'h01); chk("R11", 4'h4, 8'h07);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_protect();
        t_mask();
        t_seconds();
        t_midnight_feb();
        t_month_len();
        t_year_end();
        t_collision();
        t_overlimit();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule